// File: doc/BRIEF.md
# Packet Buffer Pointer and Byte Data Port

This block gives a byte-wide register bus access into a packet store. The store holds a set of equal-sized packet buffers and is built from inferred RAM. A 16-bit pointer register sets the byte offset inside a buffer. The same register carries two steering bits: one picks which buffer the access reaches, and the other picks how the offset moves after each access.

Software first loads the pointer through two byte registers. It then reads or writes packet bytes through a window of four data offsets. In auto-increment mode, every data access uses the current offset and then advances it by one. The offset wraps inside the buffer. In fixed mode the pointer does not move. The low two bits of the data offset are added to the pointer offset, so four neighbouring bytes can be reached without reloading it.

The buffer is chosen from one of two inputs: the head of the receive queue, or the packet-number register. Both are supplied by neighbouring logic. All reads return one cycle after the request, marked by a valid strobe.

Top module: `pktmem_port`

## Requirements
- R1: After reset the pointer is 0x0000, so reading register offset 6 (pointer low byte) and offset 7 (pointer high byte) both return 0x00.
- R2: Writing offset 6 changes only pointer bits 7:0, and writing offset 7 changes only pointer bits 15:8.
- R3: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, so pointer bit 11 always reads as 0.
- R4: Data accesses (offsets 8 to 11) reach the buffer numbered by input `rxq_head` when pointer bit 15 is 1, and the buffer numbered by input `pkt_num` when it is 0.
- R5: With pointer bit 14 set, each data access uses offset bits 10:0 and then sets bits 10:0 to (bits 10:0 + 1) mod 2048, leaving bits 15:11 unchanged. The low address bits of the data offset are ignored in this mode.
- R6: With pointer bit 14 clear, a data access at register offset 8+k (k = 0..3) reaches byte (pointer bits 10:0 + k) mod 2048 and leaves the pointer unchanged.
- R7: `rd_valid` is high exactly in the cycle after a read of offsets 6 to 11, with the requested byte on `rd_data`. It is low after idle cycles and after writes.
- R8: A data read in auto-increment mode returns the byte at the offset held before the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write byte |
| pkt_num | input | BUF_W | Buffer number from the packet-number register |
| rxq_head | input | BUF_W | Buffer number at the receive queue head |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 8 | Read byte |

## Verification
The bench targets the offset wrap in both modes: at 0x7FF in auto-increment mode, and where the fixed offset plus the address bits passes 2047. A design that carried into bit 11, or that stepped outside the buffer, would read back the wrong byte or a changed high pointer byte. Reads in auto-increment mode are checked for returning the pre-increment byte; an off-by-one design would return the next byte. Selection between the queue head and the packet number is checked by writing a value in one buffer and reading it back through the other selector. The masked bit 11 and byte-independent pointer writes are checked through the pointer read-back.

// File: rtl/pktmem_pkg.sv
package pktmem_pkg;
   localparam int PTR_W         = 16;
   localparam int SEL_RX_BIT    = 15;
   localparam int AUTO_INC_BIT  = 14;
   localparam logic [7:0] HI_READ_MASK = 8'hF7;
   localparam int REG_PTR_LO    = 6;
   localparam int REG_PTR_HI    = 7;
   localparam int REG_DATA_BASE = 8;
endpackage

// File: rtl/pktmem_ptr.sv
module pktmem_ptr
   import pktmem_pkg::*;
#(
   parameter int OFF_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   input  logic             data_acc,
   output logic [PTR_W-1:0] ptr_q
);
   logic step;
   assign step = data_acc && ptr_q[AUTO_INC_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (wr_lo)
         ptr_q[7:0] <= wdata;
      else if (wr_hi)
         ptr_q[15:8] <= wdata;
      else if (step)
         ptr_q <= {ptr_q[PTR_W-1:OFF_W], ptr_q[OFF_W-1:0] + OFF_W'(1)};
   end

   // R2
   lo_write_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> ptr_q[15:8] == $past(ptr_q[15:8]));

   // R5
   auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !wr_lo && !wr_hi && ptr_q[AUTO_INC_BIT]) |=>
      (ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + OFF_W'(1)) &&
      (ptr_q[PTR_W-1:OFF_W] == $past(ptr_q[PTR_W-1:OFF_W])));

   // R6
   fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !wr_lo && !wr_hi && !ptr_q[AUTO_INC_BIT]) |=> $stable(ptr_q));
endmodule

// File: rtl/pktmem_addr.sv
module pktmem_addr
   import pktmem_pkg::*;
#(
   parameter int OFF_W = 11,
   parameter int BUF_W = 2
) (
   input  logic [PTR_W-1:0] ptr,
   input  logic [1:0]       lane,
   input  logic [BUF_W-1:0] pkt_num,
   input  logic [BUF_W-1:0] rxq_head,
   output logic [BUF_W-1:0] buf_sel,
   output logic [OFF_W-1:0] off
);
   assign buf_sel = ptr[SEL_RX_BIT] ? rxq_head : pkt_num;
   assign off = ptr[AUTO_INC_BIT] ? ptr[OFF_W-1:0]
                                  : ptr[OFF_W-1:0] + OFF_W'(lane);
endmodule

// File: rtl/pktmem_ram.sv
module pktmem_ram #(
   parameter int NUM_BUF   = 4,
   parameter int BUF_BYTES = 2048,
   parameter int BUF_W     = 2,
   parameter int OFF_W     = 11
) (
   input  logic             clk,
   input  logic             we,
   input  logic             re,
   input  logic [BUF_W-1:0] buf_sel,
   input  logic [OFF_W-1:0] off,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   logic [NUM_BUF*8-1:0] bank_flat;
   logic [BUF_W-1:0]     sel_q;

   for (genvar g = 0; g < NUM_BUF; g++) begin : g_bank
      logic [7:0] mem [BUF_BYTES];
      logic [7:0] rd_q;
      always_ff @(posedge clk) begin
         if (we && buf_sel == BUF_W'(g))
            mem[off] <= wdata;
         if (re && buf_sel == BUF_W'(g))
            rd_q <= mem[off];
      end
      assign bank_flat[g*8 +: 8] = rd_q;
   end

   always_ff @(posedge clk) begin
      if (re)
         sel_q <= buf_sel;
   end

   assign rdata = bank_flat[32'(sel_q)*8 +: 8];
endmodule

// File: rtl/pktmem_port.sv
module pktmem_port
   import pktmem_pkg::*;
#(
   parameter int NUM_BUF   = 4,
   parameter int BUF_BYTES = 2048,
   parameter int ADDR_W    = 4,
   localparam int BUF_W    = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
   localparam int OFF_W    = $clog2(BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic [BUF_W-1:0]  pkt_num,
   input  logic [BUF_W-1:0]  rxq_head,
   output logic              rd_valid,
   output logic [7:0]        rd_data
);
   if (BUF_BYTES != (1 << OFF_W)) begin : g_bad_size
      $error("BUF_BYTES must be a power of two");
   end
   if (OFF_W > AUTO_INC_BIT) begin : g_bad_off
      $error("offset field overlaps the mode bits");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the data window");
   end
   if (NUM_BUF < 2) begin : g_bad_num
      $error("NUM_BUF must be at least 2");
   end

   logic hit_lo, hit_hi, hit_data, data_acc;
   logic [PTR_W-1:0] ptr;
   logic [BUF_W-1:0] buf_sel;
   logic [OFF_W-1:0] off;
   logic [7:0]       ram_rdata;
   logic             src_mem_q;
   logic [7:0]       ptr_byte_q;

   assign hit_lo   = reg_addr == ADDR_W'(REG_PTR_LO);
   assign hit_hi   = reg_addr == ADDR_W'(REG_PTR_HI);
   assign hit_data = reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(REG_DATA_BASE >> 2);
   assign data_acc = (reg_wr || reg_rd) && hit_data;

   pktmem_ptr #(.OFF_W(OFF_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (reg_wr && hit_lo),
      .wr_hi    (reg_wr && hit_hi),
      .wdata    (reg_wdata),
      .data_acc (data_acc),
      .ptr_q    (ptr)
   );

   pktmem_addr #(.OFF_W(OFF_W), .BUF_W(BUF_W)) u_addr (
      .ptr      (ptr),
      .lane     (reg_addr[1:0]),
      .pkt_num  (pkt_num),
      .rxq_head (rxq_head),
      .buf_sel  (buf_sel),
      .off      (off)
   );

   pktmem_ram #(.NUM_BUF(NUM_BUF), .BUF_BYTES(BUF_BYTES),
                .BUF_W(BUF_W), .OFF_W(OFF_W)) u_ram (
      .clk     (clk),
      .we      (reg_wr && hit_data),
      .re      (reg_rd && hit_data),
      .buf_sel (buf_sel),
      .off     (off),
      .wdata   (reg_wdata),
      .rdata   (ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         src_mem_q  <= 1'b0;
         ptr_byte_q <= '0;
      end else begin
         rd_valid <= reg_rd && (hit_lo || hit_hi || hit_data);
         if (reg_rd) begin
            src_mem_q  <= hit_data;
            ptr_byte_q <= hit_hi ? (ptr[15:8] & HI_READ_MASK) : ptr[7:0];
         end
      end
   end

   assign rd_data = src_mem_q ? ram_rdata : ptr_byte_q;

   // R7
   rd_valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (hit_lo || hit_hi || hit_data)) |=> rd_valid);

   // R7
   rd_valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> !rd_valid);

   // R3
   hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && hit_hi) |=> rd_data[3] == 1'b0);
endmodule

// File: tb/tb_pktmem_port.sv
module tb_pktmem_port;
   localparam int CLK_PERIOD = 10;
   localparam int OPW = 1, AW = 4;

   logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [1:0] pkt_num = 2'd2, rxq_head = 2'd1;
   logic rd_valid;
   logic [7:0] rd_data;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pktmem_port dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pkt_num(pkt_num),
      .rxq_head(rxq_head), .rd_valid(rd_valid), .rd_data(rd_data)
   );

   // entry: {read, addr, byte (write data or expected), requirement}
   localparam int N = 47;
   localparam logic [16:0] VEC [N] = '{
      {1'b0, 4'd6, 8'h10, 4'd0}, {1'b0, 4'd7, 8'h40, 4'd0},
      {1'b0, 4'd8, 8'hA1, 4'd0}, {1'b0, 4'd8, 8'hA2, 4'd0},
      {1'b0, 4'd9, 8'hA3, 4'd0},
      {1'b1, 4'd6, 8'h13, 4'd5}, {1'b1, 4'd7, 8'h40, 4'd5},   // R5 steps
      {1'b0, 4'd6, 8'h10, 4'd0}, {1'b0, 4'd7, 8'h00, 4'd0},
      {1'b1, 4'd8, 8'hA1, 4'd6}, {1'b1, 4'd9, 8'hA2, 4'd6},   // R6 lanes
      {1'b1, 4'd10, 8'hA3, 4'd6}, {1'b1, 4'd6, 8'h10, 4'd6},
      {1'b0, 4'd7, 8'h80, 4'd0}, {1'b0, 4'd8, 8'h5C, 4'd0},
      {1'b0, 4'd7, 8'h00, 4'd0}, {1'b1, 4'd8, 8'hA1, 4'd4},   // R4 select
      {1'b0, 4'd7, 8'h80, 4'd0}, {1'b1, 4'd8, 8'h5C, 4'd4},
      {1'b0, 4'd6, 8'hFF, 4'd0}, {1'b0, 4'd7, 8'h47, 4'd0},
      {1'b0, 4'd8, 8'hEE, 4'd0},
      {1'b1, 4'd6, 8'h00, 4'd5}, {1'b1, 4'd7, 8'h40, 4'd5},   // R5 wrap
      {1'b0, 4'd7, 8'h08, 4'd0}, {1'b1, 4'd7, 8'h00, 4'd3},   // R3 mask
      {1'b0, 4'd7, 8'h3F, 4'd0}, {1'b1, 4'd7, 8'h37, 4'd3},
      {1'b0, 4'd6, 8'hFE, 4'd0}, {1'b0, 4'd7, 8'h07, 4'd0},
      {1'b0, 4'd11, 8'h77, 4'd0},
      {1'b0, 4'd6, 8'h01, 4'd0}, {1'b0, 4'd7, 8'h00, 4'd0},
      {1'b1, 4'd8, 8'h77, 4'd6},                              // R6 wrap
      {1'b0, 4'd6, 8'hFF, 4'd0}, {1'b0, 4'd7, 8'h07, 4'd0},
      {1'b1, 4'd8, 8'hEE, 4'd6},
      {1'b0, 4'd6, 8'h10, 4'd0}, {1'b0, 4'd7, 8'h40, 4'd0},
      {1'b1, 4'd8, 8'hA1, 4'd8}, {1'b1, 4'd8, 8'hA2, 4'd8},   // R8 pre-inc
      {1'b1, 4'd6, 8'h12, 4'd8},
      {1'b0, 4'd6, 8'h34, 4'd0}, {1'b1, 4'd7, 8'h40, 4'd2},   // R2 split
      {1'b0, 4'd7, 8'h00, 4'd0}, {1'b1, 4'd6, 8'h34, 4'd2},
      {1'b1, 4'd7, 8'h00, 4'd2}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic rd(input logic [3:0] a, input string req, input logic [7:0] exp);
      @(negedge clk); reg_rd = 1; reg_addr = a;
      @(negedge clk); reg_rd = 0;
      check("R7 valid", {7'd0, rd_valid}, 8'd1);
      check(req, rd_data, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(4'd6, "R1 ptr lo", 8'h00);
      rd(4'd7, "R1 ptr hi", 8'h00);
      @(negedge clk);
      check("R7 idle", {7'd0, rd_valid}, 8'd0);
      for (int i = 0; i < N; i++) begin
         if (VEC[i][16]) rd(VEC[i][15:12], $sformatf("R%0d vec %0d", VEC[i][3:0], i), VEC[i][11:4]);
         else wr(VEC[i][15:12], VEC[i][11:4]);
      end
      // R7: a write produces no valid strobe
      wr(4'd8, 8'h11);
      check("R7 after write", {7'd0, rd_valid}, 8'd0);
      // R4: queue head reaches buffer 3, read back through packet number
      rxq_head = 2'd3; pkt_num = 2'd0;
      wr(4'd6, 8'h00); wr(4'd7, 8'h80); wr(4'd8, 8'h3C);
      pkt_num = 2'd3; wr(4'd7, 8'h00);
      rd(4'd8, "R4 cross", 8'h3C);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule